// File: doc/BRIEF.md
# Virtual Segment Decoder with Fault Capture

This block classifies each 32-bit virtual address presented by the load/store path, before the TLB result is used. It decides whether the address lies in a mapped window, an unmapped cached window, an unmapped uncached window, or whether the current privilege forbids it. For the two fixed kernel windows it forms the physical address itself by removing the window base. While the error-level flag is set, the low half of the space maps one-to-one. For mapped windows it passes on the physical address that the TLB returned, or turns the TLB status into an exception code.

A strobe marks each access. When the access faults, the block raises a fault flag and a cause code in the same cycle. At that clock edge it also loads three capture registers: the faulting address, a context word with the page-pair number of the fault inserted below a retained base field, and an entry-high word that holds the page-pair tag and the current address-space identifier. The page size, the identifier width and the reset value of the context base are parameters.

Top module: `vseg_xlate`

## Requirements
- R1: In user mode, any address with bit 31 set is illegal. Such an address gives kind 4, asserts `fault` and gives exception code 5 on a write or 4 on a read.
- R2: An address below 0x80000000 with the error-level flag clear is mapped (kind 0) and takes its result from the TLB.
- R3: An address below 0x80000000 with the error-level flag set gives kind 1 and `paddr` equal to the address, with no fault, whatever the TLB status and in either privilege mode.
- R4: Outside user mode, addresses 0x80000000 to 0x9FFFFFFF give kind 2 and `paddr` = address - 0x80000000, with no fault.
- R5: Outside user mode, addresses 0xA0000000 to 0xBFFFFFFF give kind 3 and `paddr` = address - 0xA0000000, with no fault.
- R6: Outside user mode, addresses from 0xC0000000 upward are mapped (kind 0) even when the error-level flag is set.
- R7: For a mapped access, TLB status 0 (hit) gives `paddr` = `tlb_paddr` and no fault. Status 1 (no match) and status 2 (entry invalid) give code 3 on a write and code 2 on a read. Status 3 (write to a clean page) gives code 1. A faulting access drives `paddr` to 0, and `exc_code` is 0 whenever there is no fault.
- R8: With `req_valid` low, `fault` stays low and the three capture registers keep their values.
- R9: At the clock edge where `fault` is high, `badaddr_q` is loaded with the faulting address.
- R10: At that edge, `context_q` becomes (old `context_q` AND 0xFF800000) OR ((address >> 9) AND 0x007FFFF0).
- R11: At that edge, `entryhi_q` becomes (address AND 0xFFFFE000) OR the 8-bit identifier `cur_asid`.
- R12: Reset gives `badaddr_q` = 0, `entryhi_q` = 0 and `context_q` = CTX_RST (default 0x12800000). An access that does not fault leaves all three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 for store, 0 for load |
| user_mode | input | 1 | Current privilege is user |
| err_level | input | 1 | Error-level flag |
| cur_asid | input | ASID_W | Current address-space identifier |
| tlb_status | input | 2 | TLB status: 0 hit, 1 no match, 2 invalid, 3 clean on write |
| tlb_paddr | input | 32 | Physical address from the TLB |
| seg_kind | output | 3 | 0 mapped, 1 identity, 2 unmapped cached, 3 unmapped uncached, 4 illegal |
| paddr | output | 32 | Physical address |
| fault | output | 1 | Access faults |
| exc_code | output | 5 | Exception cause code, 0 if none |
| badaddr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Context register |
| entryhi_q | output | 32 | Entry-high register |

## Verification
`seg_kind`, `paddr`, `fault` and `exc_code` are combinational. They are due in the cycle the inputs are applied, so the bench drives inputs on the falling edge and samples these outputs a few nanoseconds later, before the next rising edge. The capture registers change only at the rising edge that follows a fault, so the bench samples them shortly after that edge and compares them with its own register model. The model updates only when it predicts a fault. The sweep covers all eight 512 MB regions at their lowest, highest and pseudo-random offsets, with every combination of privilege, error level, direction and TLB status, and then repeats faulting patterns with the strobe low.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  typedef enum logic [2:0] {
    SEG_MAPPED   = 3'd0,
    SEG_IDENT    = 3'd1,
    SEG_CACHED   = 3'd2,
    SEG_UNCACHED = 3'd3,
    SEG_ILLEGAL  = 3'd4
  } seg_kind_e;

  typedef enum logic [1:0] {
    TLB_HIT     = 2'd0,
    TLB_MISS    = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_CLEAN   = 2'd3
  } tlb_stat_e;

  localparam logic [4:0] EXC_NONE    = 5'd0;
  localparam logic [4:0] EXC_TLB_MOD = 5'd1;
  localparam logic [4:0] EXC_TLB_LD  = 5'd2;
  localparam logic [4:0] EXC_TLB_ST  = 5'd3;
  localparam logic [4:0] EXC_ADDR_LD = 5'd4;
  localparam logic [4:0] EXC_ADDR_ST = 5'd5;

  localparam logic [31:0] WIN_CACHED_BASE   = 32'h8000_0000;
  localparam logic [31:0] WIN_UNCACHED_BASE = 32'hA000_0000;

  // Remove a fixed window base from an address.
  function automatic logic [31:0] strip_window(input logic [31:0] a,
                                               input logic [31:0] base);
    return a - base;
  endfunction

  // Context: keep the base field, insert the shifted page-pair number.
  function automatic logic [31:0] next_context(input logic [31:0] old_ctx,
                                               input logic [31:0] a,
                                               input logic [31:0] keep_mask,
                                               input int unsigned shift,
                                               input logic [31:0] field_mask);
    return (old_ctx & keep_mask) | ((a >> shift) & field_mask);
  endfunction

  // Entry-high: page-pair tag with the identifier in the low bits.
  function automatic logic [31:0] next_entryhi(input logic [31:0] a,
                                               input logic [31:0] pair_mask,
                                               input logic [31:0] ident);
    return (a & pair_mask) | ident;
  endfunction

endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
(
  input  logic [31:0] vaddr,
  input  logic        user_mode,
  input  logic        err_level,
  output seg_kind_e   kind,
  output logic [31:0] direct_paddr
);

  logic [2:0] region;
  assign region = vaddr[31:29];

  always_comb begin
    direct_paddr = '0;
    kind         = SEG_MAPPED;
    if (user_mode && vaddr[31]) begin
      kind = SEG_ILLEGAL;
    end else if (!vaddr[31]) begin
      if (err_level) begin
        kind         = SEG_IDENT;
        direct_paddr = vaddr;
      end else begin
        kind = SEG_MAPPED;
      end
    end else if (region == 3'b100) begin
      kind         = SEG_CACHED;
      direct_paddr = strip_window(vaddr, WIN_CACHED_BASE);
    end else if (region == 3'b101) begin
      kind         = SEG_UNCACHED;
      direct_paddr = strip_window(vaddr, WIN_UNCACHED_BASE);
    end else begin
      kind = SEG_MAPPED;
    end
  end

endmodule

// File: rtl/vseg_fault_sel.sv
module vseg_fault_sel
  import vseg_pkg::*;
(
  input  logic       req_valid,
  input  seg_kind_e  kind,
  input  tlb_stat_e  tlb_stat,
  input  logic       is_write,
  output logic       fault,
  output logic [4:0] exc_code
);

  logic [4:0] raw_code;

  always_comb begin
    raw_code = EXC_NONE;
    case (kind)
      SEG_ILLEGAL: raw_code = is_write ? EXC_ADDR_ST : EXC_ADDR_LD;
      SEG_MAPPED: begin
        case (tlb_stat)
          TLB_MISS, TLB_INVALID: raw_code = is_write ? EXC_TLB_ST : EXC_TLB_LD;
          TLB_CLEAN:             raw_code = EXC_TLB_MOD;
          default:               raw_code = EXC_NONE;
        endcase
      end
      default: raw_code = EXC_NONE;
    endcase
  end

  assign exc_code = req_valid ? raw_code : EXC_NONE;
  assign fault    = (exc_code != EXC_NONE);

endmodule

// File: rtl/vseg_fault_regs.sv
module vseg_fault_regs
  import vseg_pkg::*;
#(
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [31:0] CTX_RST   = 32'h1280_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_stb,
  input  logic [31:0]       vaddr,
  input  logic [ASID_W-1:0] cur_asid,
  output logic [31:0]       badaddr_q,
  output logic [31:0]       context_q,
  output logic [31:0]       entryhi_q
);

  localparam logic [31:0] PAIR_MASK  = ~((32'd1 << (PAGE_BITS + 1)) - 32'd1);
  localparam int unsigned CTX_SHIFT  = PAGE_BITS - 3;
  localparam int unsigned CTX_FLD_W  = 32 - PAGE_BITS - 1;
  localparam logic [31:0] CTX_FIELD  = ((32'd1 << CTX_FLD_W) - 32'd1) << 4;
  localparam logic [31:0] CTX_KEEP   = ~((32'd1 << (CTX_FLD_W + 4)) - 32'd1);

  logic [31:0] asid_ext;
  assign asid_ext = 32'(cur_asid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      badaddr_q <= '0;
      context_q <= CTX_RST;
      entryhi_q <= '0;
    end else if (fault_stb) begin
      badaddr_q <= vaddr;
      context_q <= next_context(context_q, vaddr, CTX_KEEP, CTX_SHIFT, CTX_FIELD);
      entryhi_q <= next_entryhi(vaddr, PAIR_MASK, asid_ext);
    end
  end

  // R12: registers hold when no fault is raised
  p_hold_no_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_stb |=> ($stable(badaddr_q) && $stable(context_q) && $stable(entryhi_q)));

  // R9: faulting address captured
  p_badaddr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |=> (badaddr_q == $past(vaddr)));

  // R10: context base field retained across a fault
  p_ctx_base_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |=> ((context_q & CTX_KEEP) == ($past(context_q) & CTX_KEEP)));

  // R11: identifier lands in the low bits of entry-high
  p_ehi_ident_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stb |=> (entryhi_q[ASID_W-1:0] == $past(cur_asid)));

endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned PAGE_BITS = 12,
  parameter logic [31:0] CTX_RST   = 32'h1280_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       vaddr,
  input  logic              is_write,
  input  logic              user_mode,
  input  logic              err_level,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [1:0]        tlb_status,
  input  logic [31:0]       tlb_paddr,
  output logic [2:0]        seg_kind,
  output logic [31:0]       paddr,
  output logic              fault,
  output logic [4:0]        exc_code,
  output logic [31:0]       badaddr_q,
  output logic [31:0]       context_q,
  output logic [31:0]       entryhi_q
);

  seg_kind_e   kind_w;
  logic [31:0] direct_w;
  tlb_stat_e   tstat_w;
  logic        fault_w;

  assign tstat_w = tlb_stat_e'(tlb_status);

  vseg_decode u_decode (
    .vaddr        (vaddr),
    .user_mode    (user_mode),
    .err_level    (err_level),
    .kind         (kind_w),
    .direct_paddr (direct_w)
  );

  vseg_fault_sel u_fsel (
    .req_valid (req_valid),
    .kind      (kind_w),
    .tlb_stat  (tstat_w),
    .is_write  (is_write),
    .fault     (fault_w),
    .exc_code  (exc_code)
  );

  vseg_fault_regs #(
    .ASID_W    (ASID_W),
    .PAGE_BITS (PAGE_BITS),
    .CTX_RST   (CTX_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_stb (fault_w),
    .vaddr     (vaddr),
    .cur_asid  (cur_asid),
    .badaddr_q (badaddr_q),
    .context_q (context_q),
    .entryhi_q (entryhi_q)
  );

  always_comb begin
    if (kind_w == SEG_MAPPED)
      paddr = (tstat_w == TLB_HIT) ? tlb_paddr : '0;
    else if (kind_w == SEG_ILLEGAL)
      paddr = '0;
    else
      paddr = direct_w;
  end

  assign seg_kind = 3'(kind_w);
  assign fault    = fault_w;

  // R1: user access to the upper half faults with an address error
  p_user_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && vaddr[31]) |->
      (fault && (exc_code == (is_write ? 5'd5 : 5'd4))));

  // R3: error-level identity map never faults
  p_err_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_level && !vaddr[31]) |-> (!fault && paddr == vaddr));

  // R4: cached kernel window strips its base
  p_cached_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && vaddr[31:29] == 3'b100) |->
      (!fault && paddr == {3'b000, vaddr[28:0]}));

  // R8: no strobe, no fault
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !fault);

endmodule

// File: tb/test_vseg_xlate.sv
module test_vseg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_write = 1'b0;
  logic        user_mode = 1'b0;
  logic        err_level = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic [1:0]  tlb_status = '0;
  logic [31:0] tlb_paddr = '0;
  logic [2:0]  seg_kind;
  logic [31:0] paddr;
  logic        fault;
  logic [4:0]  exc_code;
  logic [31:0] badaddr_q, context_q, entryhi_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] m_bad, m_ctx, m_ehi;
  logic [31:0] seed = 32'h1357_9BDF;

  always #10 clk = ~clk;

  vseg_xlate i_vseg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .is_write(is_write), .user_mode(user_mode), .err_level(err_level),
    .cur_asid(cur_asid), .tlb_status(tlb_status), .tlb_paddr(tlb_paddr),
    .seg_kind(seg_kind), .paddr(paddr), .fault(fault), .exc_code(exc_code),
    .badaddr_q(badaddr_q), .context_q(context_q), .entryhi_q(entryhi_q)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Independent model from the requirements
  task automatic expect_comb(input logic v, input logic [31:0] a, input logic w,
                             input logic u, input logic e, input logic [1:0] ts,
                             input logic [31:0] tp, output logic [2:0] k,
                             output logic [31:0] p, output logic f,
                             output logic [4:0] c, output string tag);
    logic [4:0] raw;
    raw = 5'd0;
    p   = 32'd0;
    if (u && a >= 32'h8000_0000) begin
      k = 3'd4; raw = w ? 5'd5 : 5'd4; tag = "R1";
    end else if (a < 32'h8000_0000 && e) begin
      k = 3'd1; p = a; tag = "R3";
    end else if (a >= 32'h8000_0000 && a < 32'hA000_0000) begin
      k = 3'd2; p = a - 32'h8000_0000; tag = "R4";
    end else if (a >= 32'hA000_0000 && a < 32'hC000_0000) begin
      k = 3'd3; p = a - 32'hA000_0000; tag = "R5";
    end else begin
      k = 3'd0;
      tag = (a < 32'h8000_0000) ? "R2" : "R6";
      if (ts == 2'd0) p = tp;
      else if (ts == 2'd3) raw = 5'd1;
      else raw = w ? 5'd3 : 5'd2;
      if (ts != 2'd0) tag = "R7";
    end
    c = v ? raw : 5'd0;
    f = (c != 5'd0);
  endtask

  task automatic apply(input logic v, input logic [31:0] a, input logic w,
                       input logic u, input logic e, input logic [1:0] ts);
    logic [2:0] k; logic [31:0] p; logic f; logic [4:0] c; string tag;
    logic [31:0] tp;
    @(negedge clk);
    seed = step(seed);
    tp = seed;
    req_valid = v; vaddr = a; is_write = w; user_mode = u; err_level = e;
    tlb_status = ts; tlb_paddr = tp; cur_asid = seed[15:8];
    expect_comb(v, a, w, u, e, ts, tp, k, p, f, c, tag);
    #4;
    check(tag, "seg_kind", 32'(seg_kind), 32'(k));
    check(v ? tag : "R8", "fault", 32'(fault), 32'(f));
    check(v ? ((ts != 2'd0 && k == 3'd0) ? "R7" : tag) : "R8", "exc_code",
          32'(exc_code), 32'(c));
    check((f && k == 3'd0) ? "R7" : tag, "paddr", paddr, p);
    if (f) begin
      m_bad = a;
      m_ctx = (m_ctx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
      m_ehi = (a & 32'hFFFF_E000) | {24'd0, seed[15:8]};
    end
    @(posedge clk);
    #2;
    check(f ? "R9" : (v ? "R12" : "R8"), "badaddr_q", badaddr_q, m_bad);
    check(f ? "R10" : (v ? "R12" : "R8"), "context_q", context_q, m_ctx);
    check(f ? "R11" : (v ? "R12" : "R8"), "entryhi_q", entryhi_q, m_ehi);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] a;
    m_bad = 32'd0; m_ctx = 32'h1280_0000; m_ehi = 32'd0;
    repeat (3) @(posedge clk);
    #2;
    check("R12", "reset badaddr_q", badaddr_q, 32'd0);
    check("R12", "reset context_q", context_q, 32'h1280_0000);
    check("R12", "reset entryhi_q", entryhi_q, 32'd0);
    check("R8", "reset fault", 32'(fault), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep: every region at low, high and pseudo-random offsets
    for (int r = 0; r < 8; r++) begin
      for (int o = 0; o < 3; o++) begin
        for (int m = 0; m < 32; m++) begin
          seed = step(seed);
          if (o == 0) a = {r[2:0], 29'd0};
          else if (o == 1) a = {r[2:0], {29{1'b1}}};
          else a = {r[2:0], seed[28:0]};
          apply(1'b1, a, m[0], m[1], m[2], m[4:3]);
        end
      end
    end

    // Strobe low with patterns that would otherwise fault
    for (int m = 0; m < 16; m++) begin
      seed = step(seed);
      apply(1'b0, {m[0], 2'b11, seed[28:0]} | 32'h8000_0000, m[1], 1'b1,
            m[2], m[3] ? 2'd1 : 2'd3);
      apply(1'b0, {1'b0, seed[30:0]}, m[1], m[0], 1'b0, 2'd2);
    end

    // A final fault after the idle stretch, then a hit that must hold state
    apply(1'b1, 32'hC000_2468, 1'b1, 1'b0, 1'b1, 2'd3);
    apply(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule